// File: doc/BRIEF.md
# Request-Triggered Single-Move Transfer Channels

A bank of eight small transfer channels sitting beside a processor. Each channel is programmed with a source address, a destination address, a transfer count and a control word. When a peripheral raises its service request and the channel is granted, the block moves one byte or one word from source to destination. The move uses a single bus cycle, which is taken from the processor. Program flow is not redirected.

After each move the control word selects which pointer steps forward, either the source or the destination, never both. The count drops by one per move. A count of all ones marks a channel as continuous, and such a channel never counts down. Once the count has reached zero, a granted request does no memory access. Instead the block raises that channel's interrupt output, so the request is handled as an ordinary interrupt by the interrupt controller outside the block.

The memory port has separate read and write halves. Read data returns combinationally in the same cycle, so the read and the write of one move share a single clock cycle. Grant, memory strobes and interrupt pulses are combinational from the request inputs. Channel state updates at the clock edge that closes the service cycle.

Top module: `evt_xfer_dma`

## Requirements
- R1: Each channel has a 16-bit source pointer, a 16-bit destination pointer, an 8-bit count and a 3-bit control word. These are written through the setup port with `cfg_sel_i` = 0 source, 1 destination, 2 count (data bits 7:0) and 3 control (data bits 2:0). The write takes effect at the next clock edge. Reset clears every field to zero.
- R2: When several requests are high in a cycle, only the lowest-numbered one is granted. `gnt_o` is one-hot, appears in the same cycle as the request, and only goes to a requesting channel. The other channels wait.
- R3: A granted channel with a nonzero count performs one move in that cycle. It sets `mem_rd_addr_o` to the source, `mem_wr_addr_o` to the destination and `mem_word_o` to the size, and writes the read data unchanged. For a byte move, bits 15:8 of the write data are zero.
- R4: Control bits 1:0 select the pointer that advances after a move: 01 advances the destination, 10 advances the source, and 00 or 11 advance neither. Control bit 2 = 1 selects a word move. The step is 2 for a word move and 1 for a byte move.
- R5: Each move lowers the channel's count by one.
- R6: A granted channel whose count is zero makes no memory access. It pulses its own `irq_o` bit for that one cycle together with its grant, and its pointers and count stay unchanged.
- R7: A count of 0xFF is continuous: it never decrements, and every grant performs a move.
- R8: A setup write to a channel in the same cycle as that channel's service takes priority. The move still happens, but it updates no pointer and no count of that channel in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Setup write strobe |
| cfg_chan_i | input | 3 | Channel addressed by the setup write |
| cfg_sel_i | input | 2 | Field select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata_i | input | 16 | Setup write data |
| req_i | input | 8 | Per-channel service request, held until granted |
| gnt_o | output | 8 | One-hot grant, same cycle as service |
| irq_o | output | 8 | One-cycle interrupt pulse on an exhausted channel |
| mem_rd_en_o | output | 1 | Memory read strobe |
| mem_rd_addr_o | output | 16 | Memory read address (source) |
| mem_rd_data_i | input | 16 | Memory read data, same cycle |
| mem_wr_en_o | output | 1 | Memory write strobe |
| mem_wr_addr_o | output | 16 | Memory write address (destination) |
| mem_wr_data_o | output | 16 | Memory write data |
| mem_word_o | output | 1 | 1 = word move, 0 = byte move |

## Verification
The move is exercised with a word channel that steps its destination and a byte channel that steps its source. The sequence of addresses across repeated grants separates the two step sizes and tells which pointer advanced. Counts run down to zero and are then requested again, which distinguishes an exhausted channel from a live one: the exhausted channel must raise an interrupt, make no access and keep its state. A continuous channel, simultaneous requests on two channels, and a setup write that collides with a service check the 0xFF exception, the fixed priority and the precedence of setup over the update.

// File: rtl/evt_xfer_dma_pkg.sv
package evt_xfer_dma_pkg;
  typedef enum logic [1:0] {
    SEL_SRC  = 2'd0,
    SEL_DST  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_CTRL = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_DST  = 2'd1,
    STEP_SRC  = 2'd2,
    STEP_RSVD = 2'd3
  } step_e;

  typedef struct packed {
    logic  word;
    step_e step;
  } ctrl_t;
endpackage

// File: rtl/evt_xfer_dma_arb.sv
module evt_xfer_dma_arb #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o = '0;
        gnt_o[i] = 1'b1;
        idx_o = IW'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/evt_xfer_dma_chan.sv
module evt_xfer_dma_chan
  import evt_xfer_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  cfg_sel_e      cfg_sel_i,
  input  logic [AW-1:0] cfg_wdata_i,
  input  logic          svc_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [CW-1:0] cnt_o,
  output ctrl_t         ctrl_o,
  output logic          empty_o
);
  localparam int TW = $bits(ctrl_t);
  localparam logic [CW-1:0] CONT = '1;

  logic [AW-1:0] step;
  logic          moving;
  logic [AW-1:0] unused_wdata;

  assign unused_wdata = cfg_wdata_i;
  assign empty_o = (cnt_o == '0);
  assign moving  = svc_i && !empty_o;
  assign step    = ctrl_o.word ? AW'(2) : AW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o  <= '0;
      dst_o  <= '0;
      cnt_o  <= '0;
      ctrl_o <= '0;
    end else if (cfg_we_i) begin
      // setup beats a same-cycle service update
      unique case (cfg_sel_i)
        SEL_SRC:  src_o  <= cfg_wdata_i;
        SEL_DST:  dst_o  <= cfg_wdata_i;
        SEL_CNT:  cnt_o  <= cfg_wdata_i[CW-1:0];
        SEL_CTRL: ctrl_o <= ctrl_t'(cfg_wdata_i[TW-1:0]);
        default: ;
      endcase
    end else if (moving) begin
      if (ctrl_o.step == STEP_SRC) src_o <= src_o + step;
      if (ctrl_o.step == STEP_DST) dst_o <= dst_o + step;
      if (cnt_o != CONT) cnt_o <= cnt_o - 1'b1;
    end
  end
endmodule

// File: rtl/evt_xfer_dma.sv
module evt_xfer_dma
  import evt_xfer_dma_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int CW   = 8,
  localparam int IW  = $clog2(N_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [IW-1:0]   cfg_chan_i,
  input  logic [1:0]      cfg_sel_i,
  input  logic [AW-1:0]   cfg_wdata_i,
  input  logic [N_CH-1:0] req_i,
  output logic [N_CH-1:0] gnt_o,
  output logic [N_CH-1:0] irq_o,
  output logic            mem_rd_en_o,
  output logic [AW-1:0]   mem_rd_addr_o,
  input  logic [DW-1:0]   mem_rd_data_i,
  output logic            mem_wr_en_o,
  output logic [AW-1:0]   mem_wr_addr_o,
  output logic [DW-1:0]   mem_wr_data_o,
  output logic            mem_word_o
);
  logic [N_CH-1:0] gnt;
  logic [IW-1:0]   win;
  logic            any;
  logic [AW-1:0]   src   [N_CH];
  logic [AW-1:0]   dst   [N_CH];
  logic [CW-1:0]   cnt   [N_CH];
  ctrl_t           ctrl  [N_CH];
  logic [N_CH-1:0] empty;
  logic            live;

  evt_xfer_dma_arb #(.N(N_CH)) u_arb (
    .req_i (req_i),
    .gnt_o (gnt),
    .idx_o (win),
    .any_o (any)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    evt_xfer_dma_chan #(.AW(AW), .CW(CW)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cfg_we_i    (cfg_we_i && (cfg_chan_i == IW'(k))),
      .cfg_sel_i   (cfg_sel_e'(cfg_sel_i)),
      .cfg_wdata_i (cfg_wdata_i),
      .svc_i       (gnt[k]),
      .src_o       (src[k]),
      .dst_o       (dst[k]),
      .cnt_o       (cnt[k]),
      .ctrl_o      (ctrl[k]),
      .empty_o     (empty[k])
    );
  end

  assign live          = any && !empty[win];
  assign gnt_o         = gnt;
  assign irq_o         = gnt & empty;
  assign mem_rd_en_o   = live;
  assign mem_wr_en_o   = live;
  assign mem_rd_addr_o = src[win];
  assign mem_wr_addr_o = dst[win];
  assign mem_word_o    = ctrl[win].word;
  assign mem_wr_data_o = ctrl[win].word ? mem_rd_data_i
                                        : {{(DW-8){1'b0}}, mem_rd_data_i[7:0]};
endmodule

// File: rtl/evt_xfer_dma_chk.sv
module evt_xfer_dma_chk #(
  parameter int N_CH = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_CH-1:0] req_i,
  input logic [N_CH-1:0] gnt_o,
  input logic [N_CH-1:0] irq_o,
  input logic            mem_rd_en_o,
  input logic            mem_wr_en_o
);
  assert_gnt_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  assert_gnt_lowest_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o) |-> (((gnt_o & ~req_i) == '0) && (((gnt_o - 1'b1) & req_i) == '0)));

  assert_gnt_live_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> (|gnt_o));

  assert_irq_noaccess_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> (!mem_rd_en_o && !mem_wr_en_o));

  assert_irq_with_gnt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~gnt_o) == '0);

  assert_move_strobes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|gnt_o) && !(|irq_o)) |-> (mem_rd_en_o && mem_wr_en_o));

  assert_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|gnt_o) |-> (!mem_rd_en_o && !mem_wr_en_o && irq_o == '0));
endmodule

bind evt_xfer_dma evt_xfer_dma_chk #(.N_CH(N_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .gnt_o       (gnt_o),
  .irq_o       (irq_o),
  .mem_rd_en_o (mem_rd_en_o),
  .mem_wr_en_o (mem_wr_en_o)
);

// File: tb/tb_evt_xfer_dma.sv
`timescale 1ns/1ps
module tb_evt_xfer_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_chan = '0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic [7:0]  req = '0;
  logic [7:0]  gnt, irq;
  logic        rd_en, wr_en, word;
  logic [15:0] rd_addr, wr_addr, wr_data, rd_data;
  logic [7:0]  mem [256];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  // captured in the service cycle
  logic [7:0]  c_gnt, c_irq;
  logic        c_rd, c_wr, c_word;
  logic [15:0] c_ra, c_wa, c_wd, c_exp;

  always #2.5 clk = ~clk;

  evt_xfer_dma dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_chan_i(cfg_chan), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .req_i(req), .gnt_o(gnt), .irq_o(irq),
    .mem_rd_en_o(rd_en), .mem_rd_addr_o(rd_addr), .mem_rd_data_i(rd_data),
    .mem_wr_en_o(wr_en), .mem_wr_addr_o(wr_addr), .mem_wr_data_o(wr_data),
    .mem_word_o(word)
  );

  assign rd_data = word ? {mem[8'(rd_addr + 16'd1)], mem[rd_addr[7:0]]}
                        : {8'h00, mem[rd_addr[7:0]]};

  always @(posedge clk) if (wr_en) begin
    mem[wr_addr[7:0]] <= wr_data[7:0];
    if (word) mem[8'(wr_addr + 16'd1)] <= wr_data[15:8];
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int ch, input int sel, input logic [15:0] d);
    cfg_we = 1'b1; cfg_chan = 3'(ch); cfg_sel = 2'(sel); cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic setup(input int ch, input logic [15:0] s, input logic [15:0] d,
                       input logic [7:0] n, input logic [2:0] ctl);
    cfg(ch, 0, s); cfg(ch, 1, d); cfg(ch, 2, {8'h00, n}); cfg(ch, 3, {13'd0, ctl});
  endtask

  // one service cycle; expected data taken from the bench memory before the write
  task automatic serve(input logic [7:0] m);
    req = m; #1;
    c_gnt = gnt; c_irq = irq; c_rd = rd_en; c_wr = wr_en; c_word = word;
    c_ra = rd_addr; c_wa = wr_addr; c_wd = wr_data;
    c_exp = word ? {mem[8'(rd_addr + 16'd1)], mem[rd_addr[7:0]]} : {8'h00, mem[rd_addr[7:0]]};
    @(posedge clk); #1;
    req = '0;
  endtask

  task automatic t_reset;
    #1;
    check("R1 reset gnt", gnt, 0);
    check("R1 reset irq", irq, 0);
    check("R1 reset strobes", {rd_en, wr_en}, 0);
    serve(8'h01);
    check("R1 reset count zero gives irq R6", c_irq, 8'h01);
    check("R6 no access at zero", {c_rd, c_wr}, 0);
  endtask

  task automatic t_word_dst;
    setup(2, 16'h0010, 16'h0040, 8'd2, 3'b101);
    serve(8'h04);
    check("R2 grant ch2", c_gnt, 8'h04);
    check("R3 read addr", c_ra, 16'h0010);
    check("R3 write addr", c_wa, 16'h0040);
    check("R3 word size", c_word, 1);
    check("R3 word data", c_wd, c_exp);
    check("R3 mem written", {mem[8'h41], mem[8'h40]}, c_exp);
    serve(8'h04);
    check("R4 dst step 2", c_wa, 16'h0042);
    check("R4 src held", c_ra, 16'h0010);
    serve(8'h04);
    check("R5 count ran out irq", c_irq, 8'h04);
    check("R6 no access", {c_rd, c_wr}, 0);
    serve(8'h04);
    check("R6 irq again, state kept", c_irq, 8'h04);
    cfg(2, 2, 16'h0001);
    serve(8'h04);
    check("R6 pointers unchanged after irq", c_wa, 16'h0044);
  endtask

  task automatic t_byte_src;
    setup(5, 16'h0020, 16'h0080, 8'd3, 3'b010);
    serve(8'h20);
    check("R3 byte size", c_word, 0);
    check("R3 byte data upper zero", c_wd, c_exp);
    check("R3 byte read addr", c_ra, 16'h0020);
    serve(8'h20);
    check("R4 src step 1", c_ra, 16'h0021);
    check("R4 dst held", c_wa, 16'h0080);
    check("R3 byte write", {8'h00, mem[8'h80]}, c_exp);
    serve(8'h20);
    check("R5 third move live", {c_rd, c_irq}, {1'b1, 8'h00});
    serve(8'h20);
    check("R5 count 3 exhausted", c_irq, 8'h20);
  endtask

  task automatic t_priority;
    setup(1, 16'h0030, 16'h00A0, 8'd4, 3'b000);
    setup(6, 16'h0034, 16'h00B0, 8'd4, 3'b000);
    serve(8'h42);
    check("R2 lowest wins", c_gnt, 8'h02);
    check("R2 ch1 addr", c_wa, 16'h00A0);
    serve(8'h40);
    check("R2 ch6 served later", c_gnt, 8'h40);
    check("R2 ch6 addr", c_wa, 16'h00B0);
    setup(3, 16'h0050, 16'h00C0, 8'd0, 3'b011);
    serve(8'h08);
    check("R4 mode 11 still irq at zero", c_irq, 8'h08);
    cfg(3, 2, 16'h0002);
    serve(8'h08); serve(8'h08);
    check("R4 mode 11 steps nothing", {c_ra, c_wa}, {16'h0050, 16'h00C0});
  endtask

  task automatic t_continuous;
    setup(7, 16'h0060, 16'h00D0, 8'hFF, 3'b101);
    for (int i = 0; i < 6; i++) begin
      serve(8'h80);
      check("R7 continuous moves", {c_rd, c_irq}, {1'b1, 8'h00});
      check("R7 continuous addr", c_wa, 16'h00D0 + 16'(2 * i));
    end
  endtask

  task automatic t_collide;
    setup(4, 16'h0070, 16'h00E0, 8'd1, 3'b001);
    cfg_we = 1'b1; cfg_chan = 3'd4; cfg_sel = 2'd2; cfg_wdata = 16'h0003;
    serve(8'h10);
    cfg_we = 1'b0;
    check("R8 move still made", c_rd, 1);
    serve(8'h10);
    check("R8 dst not stepped", c_wa, 16'h00E0);
    check("R8 written count live", c_irq, 8'h00);
    serve(8'h10); serve(8'h10);
    check("R8 count 3 then exhausted", c_irq, 8'h00);
    serve(8'h10);
    check("R8 exhausted after 3", c_irq, 8'h10);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 3 + 1);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_word_dst();
    t_byte_src();
    t_priority();
    t_continuous();
    t_collide();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule